// File: doc/BRIEF.md
# Multiplexed Cache Event Counter Bank

This block counts cache activity for performance monitoring. The cache supplies single-cycle event pulses on two slices, with eleven event codes per slice. Each live event in each slice has its own wrapping accumulator, so no count is lost while a different event is being viewed. Software sees all of this through a control register and two counter words. The control register chooses which event is viewed, on which channel, and can freeze or clear counting.

The two counter words show the selected event's count for slice 0 and for slice 1. The full total for an event is their sum. Each counter word also carries the code of the event it is currently showing. After changing the selection, software polls until that echoed code matches before it trusts the count. The code and the count always change in the same cycle, so a matching code never comes with a stale count.

Top module: `cache_evt_cntr_bank`

## Requirements
- R1: The control register is at byte offset 0x08. Bit 8 is freeze, bits 19:16 are the event code and bit 20 is the channel (0 = read, 1 = write). Bit 0 is a clear strobe that reads back 0, and all other bits read 0. After reset the register reads 0.
- R2: The counter word at 0x10 shows slice 0 and the word at 0x18 shows slice 1. Bits CNT_W-1:0 hold the count for the viewed event and bits 63:60 echo the viewed code. All bits between them read 0. The event total is the sum of the two words.
- R3: A pulse on ev_pulse bit s*11+e adds one to the accumulator of event e in slice s. All accumulators keep counting whichever event is selected.
- R4: While freeze is set, every event pulse is ignored.
- R5: Codes 0x1, 0x3, 0x6 and 0x7 belong to the write channel; every other code belongs to the read channel. A counter word shows a nonzero count only when the channel bit matches the channel of the selected code; otherwise its count reads 0.
- R6: A write with bit 0 set clears every accumulator at that clock edge. The clear wins over a pulse that arrives in the same cycle.
- R7: Code 0x4 and codes 0xB to 0xF always show a count of 0, and pulses on event bit 4 have no effect.
- R8: After a control write is accepted at one clock edge, the echoed code and the count both switch at the fourth clock edge after it. With the selection held, a pulse appears in the count word one edge after the edge that counted it.
- R9: Each accumulator wraps modulo 2^CNT_W.
- R10: A read from any address other than 0x08, 0x10 or 0x18 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | 64 | Write data |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | 64 | Read data, combinational from registers |
| ev_pulse | input | 22 | Event pulses, slice s event e on bit s*11+e |

## Verification
A control write lands at edge E0. The bench samples the counter words on the falling edges after E0 through E3 and expects the old code and count. After E4 it expects the new code and count. For a single pulse, the bench reads the count after the counting edge, expecting the old value, and again one edge later, expecting the new value. In the sweeps over all 16 codes and both channels, the bench waits five cycles after each selection before reading, so every result is already settled.

// File: rtl/cevc_pkg.sv
package cevc_pkg;
   localparam int CODE_W     = 4;
   localparam int NUM_CODES  = 1 << CODE_W;
   localparam int NUM_EV     = 11;
   localparam int NUM_SLICES = 2;
   localparam int RSVD_CODE  = 4;

   localparam int OFS_CTRL   = 'h08;
   localparam int OFS_VIEW0  = 'h10;
   localparam int OFS_VIEW1  = 'h18;

   localparam int B_CLR      = 0;
   localparam int B_FRZ      = 8;
   localparam int B_CODE     = 16;
   localparam int B_CHAN     = 20;
   localparam int B_ECHO     = 60;

   function automatic logic code_live(input logic [CODE_W-1:0] c);
      return (int'(c) < NUM_EV) && (int'(c) != RSVD_CODE);
   endfunction

   function automatic logic code_chan(input logic [CODE_W-1:0] c);
      return (c == 4'h1) || (c == 4'h3) || (c == 4'h6) || (c == 4'h7);
   endfunction
endpackage

// File: rtl/cevc_accum.sv
module cevc_accum #(
   parameter int W = 48
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         frz,
   input  logic         pulse,
   output logic [W-1:0] cnt
);
   always_ff @(posedge clk) begin
      if (!rst_n || clr)
         cnt <= '0;
      else if (pulse && !frz)
         cnt <= cnt + W'(1);
   end

   a_r3_incr: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse && !frz && !clr) |=> (cnt == $past(cnt) + W'(1)));
   a_r4_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (frz && !clr) |=> (cnt == $past(cnt)));
   a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));
endmodule

// File: rtl/cevc_sel_pipe.sv
module cevc_sel_pipe #(
   parameter int W     = 5,
   parameter int DEPTH = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (DEPTH < 0) begin : g_bad
      $error("cevc_sel_pipe: DEPTH must be non-negative");
   end

   if (DEPTH == 0) begin : g_thru
      assign q = d;
   end else begin : g_regs
      logic [W-1:0] stg [DEPTH];
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
         end else begin
            stg[0] <= d;
            for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
         end
      end
      assign q = stg[DEPTH-1];
   end
endmodule

// File: rtl/cache_evt_cntr_bank.sv
module cache_evt_cntr_bank
   import cevc_pkg::*;
#(
   parameter int CNT_W  = 48,
   parameter int ADDR_W = 8,
   parameter int LAT    = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [63:0]                wr_data,
   input  logic [ADDR_W-1:0]          rd_addr,
   output logic [63:0]                rd_data,
   input  logic [NUM_SLICES*NUM_EV-1:0] ev_pulse
);
   localparam int PIPE_D = LAT - 1;
   localparam int SEL_W  = CODE_W + 1;

   if (CNT_W < 1 || CNT_W > B_ECHO) begin : g_bad_w
      $error("cache_evt_cntr_bank: CNT_W out of range");
   end
   if (LAT < 1) begin : g_bad_lat
      $error("cache_evt_cntr_bank: LAT must be at least 1");
   end
   if (ADDR_W < 5) begin : g_bad_a
      $error("cache_evt_cntr_bank: ADDR_W too small for the map");
   end

   // control register
   logic              ctrl_wr, clr;
   logic              frz_q, chan_q;
   logic [CODE_W-1:0] code_q;

   assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(OFS_CTRL));
   assign clr     = ctrl_wr && wr_data[B_CLR];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frz_q  <= 1'b0;
         chan_q <= 1'b0;
         code_q <= '0;
      end else if (ctrl_wr) begin
         frz_q  <= wr_data[B_FRZ];
         chan_q <= wr_data[B_CHAN];
         code_q <= wr_data[B_CODE +: CODE_W];
      end
   end

   // selection delay line
   logic [SEL_W-1:0] sel_d;
   cevc_sel_pipe #(.W(SEL_W), .DEPTH(PIPE_D)) u_pipe (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({chan_q, code_q}),
      .q     (sel_d)
   );

   logic              sel_chan;
   logic [CODE_W-1:0] sel_code;
   assign sel_chan = sel_d[CODE_W];
   assign sel_code = sel_d[CODE_W-1:0];

   // per-slice, per-event accumulators
   logic [CNT_W-1:0] acc [NUM_SLICES][NUM_CODES];

   for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
      for (genvar e = 0; e < NUM_CODES; e++) begin : g_ev
         if (code_live(CODE_W'(e))) begin : g_live
            cevc_accum #(.W(CNT_W)) u_acc (
               .clk   (clk),
               .rst_n (rst_n),
               .clr   (clr),
               .frz   (frz_q),
               .pulse (ev_pulse[s*NUM_EV + e]),
               .cnt   (acc[s][e])
            );
         end else begin : g_dead
            assign acc[s][e] = '0;
         end
      end
   end

   // viewing window: code and counts refresh together
   logic              show;
   logic [CODE_W-1:0] view_code_q;
   logic [CNT_W-1:0]  view_cnt_q [NUM_SLICES];

   assign show = code_live(sel_code) && (sel_chan == code_chan(sel_code));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         view_code_q <= '0;
         for (int s = 0; s < NUM_SLICES; s++) view_cnt_q[s] <= '0;
      end else begin
         view_code_q <= sel_code;
         for (int s = 0; s < NUM_SLICES; s++)
            view_cnt_q[s] <= show ? acc[s][sel_code] : '0;
      end
   end

   // read mux
   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_W'(OFS_CTRL))
         rd_data = (64'(frz_q) << B_FRZ) | (64'(code_q) << B_CODE) |
                   (64'(chan_q) << B_CHAN);
      else if (rd_addr == ADDR_W'(OFS_VIEW0))
         rd_data = (64'(view_code_q) << B_ECHO) | 64'(view_cnt_q[0]);
      else if (rd_addr == ADDR_W'(OFS_VIEW1))
         rd_data = (64'(view_code_q) << B_ECHO) | 64'(view_cnt_q[1]);
   end

   a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !code_live(view_code_q) |-> (view_cnt_q[0] == '0 && view_cnt_q[1] == '0));
   a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr != ADDR_W'(OFS_CTRL) && rd_addr != ADDR_W'(OFS_VIEW0) &&
       rd_addr != ADDR_W'(OFS_VIEW1)) |-> (rd_data == 64'd0));
endmodule

// File: tb/cache_evt_cntr_bank_tb.sv
module cache_evt_cntr_bank_tb;
   localparam int CW = 8;
   localparam int NE = 11;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [63:0] wr_data = '0;
   logic [7:0]  rd_addr = '0;
   logic [63:0] rd_data;
   logic [2*NE-1:0] ev = '0;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   cache_evt_cntr_bank #(.CNT_W(CW), .ADDR_W(8), .LAT(4)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .ev_pulse(ev)
   );

   task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr_ctrl(input logic [63:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 8'h08; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [63:0] v);
      rd_addr = a;
      #1;
      v = rd_data;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   function automatic int exp_cnt(input int e, input int s);
      if (e > 10 || e == 4) return 0;
      return 3*e + 5*s + 1;
   endfunction

   function automatic int chan_of(input int e);
      return (e == 1 || e == 3 || e == 6 || e == 7) ? 1 : 0;
   endfunction

   initial begin
      #(200000*8);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [63:0] v0, v1;
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 / R2 reset state
      rd(8'h08, v0); check(v0, 64'd0, "R1 ctrl after reset");
      rd(8'h10, v0); check(v0, 64'd0, "R2 view0 after reset");
      rd(8'h18, v0); check(v0, 64'd0, "R2 view1 after reset");

      // R10 unmapped addresses
      rd(8'h00, v0); check(v0, 64'd0, "R10 addr 0x00");
      rd(8'h20, v0); check(v0, 64'd0, "R10 addr 0x20");
      rd(8'h09, v0); check(v0, 64'd0, "R10 addr 0x09");

      // R1 readback of fields, strobe and junk bits read 0
      wr_ctrl((64'd1 << 8) | (64'd5 << 16) | (64'd1 << 20) | 64'd1 | (64'd1 << 30));
      rd(8'h08, v0);
      check(v0, (64'd1 << 8) | (64'd5 << 16) | (64'd1 << 20), "R1 ctrl readback");

      // clear and unfreeze, then drive the pulse pattern (R3, R7 bit 4 too)
      wr_ctrl(64'd1);
      for (int k = 0; k < 40; k++) begin
         for (int s = 0; s < 2; s++)
            for (int e = 0; e < NE; e++)
               ev[s*NE + e] = (k < 3*e + 5*s + 1);
         @(negedge clk);
      end
      ev = '0;
      idle(2);

      // sweep every code and both channels (R2, R3, R5, R7)
      for (int c = 0; c < 16; c++) begin
         for (int ch = 0; ch < 2; ch++) begin
            int x0, x1;
            wr_ctrl((64'(c) << 16) | (64'(ch) << 20));
            idle(5);
            rd(8'h10, v0);
            rd(8'h18, v1);
            x0 = (ch == chan_of(c)) ? exp_cnt(c, 0) : 0;
            x1 = (ch == chan_of(c)) ? exp_cnt(c, 1) : 0;
            check(64'(v0[63:60]), 64'(c), "R2 echo view0");
            check(64'(v1[63:60]), 64'(c), "R2 echo view1");
            check(64'(v0[59:0]), 64'(x0), "R5/R7 count view0");
            check(64'(v1[59:0]), 64'(x1), "R5/R7 count view1");
            check(64'(v0[CW-1:0]) + 64'(v1[CW-1:0]), 64'(x0 + x1), "R2 total sum");
         end
      end

      // R8 selection latency
      wr_ctrl(64'd2 << 16);
      idle(5);
      wr_ctrl(64'd8 << 16);            // accepted at E0, now after E0
      for (int i = 0; i < 4; i++) begin // after E0..E3
         rd(8'h10, v0);
         check(64'(v0[63:60]), 64'd2, "R8 echo still old");
         check(64'(v0[59:0]), 64'(exp_cnt(2, 0)), "R8 count still old");
         if (i < 3) @(negedge clk);
      end
      @(negedge clk);                   // after E4
      rd(8'h10, v0);
      check(64'(v0[63:60]), 64'd8, "R8 echo switched");
      check(64'(v0[59:0]), 64'(exp_cnt(8, 0)), "R8 count switched");

      // R8 / R3 one-pulse refresh
      ev[8] = 1'b1;
      @(negedge clk);
      ev[8] = 1'b0;
      rd(8'h10, v0); check(64'(v0[CW-1:0]), 64'(exp_cnt(8, 0)), "R8 count before refresh");
      @(negedge clk);
      rd(8'h10, v0); check(64'(v0[CW-1:0]), 64'(exp_cnt(8, 0) + 1), "R3 count after pulse");

      // R4 freeze
      wr_ctrl((64'd1 << 8) | (64'd8 << 16));
      ev[8] = 1'b1; ev[NE + 8] = 1'b1;
      idle(10);
      ev = '0;
      idle(6);
      rd(8'h10, v0); check(64'(v0[CW-1:0]), 64'(exp_cnt(8, 0) + 1), "R4 frozen slice0");
      rd(8'h18, v0); check(64'(v0[CW-1:0]), 64'(exp_cnt(8, 1)), "R4 frozen slice1");
      wr_ctrl(64'd8 << 16);
      ev[8] = 1'b1;
      @(negedge clk);
      ev = '0;
      idle(2);
      rd(8'h10, v0); check(64'(v0[CW-1:0]), 64'(exp_cnt(8, 0) + 2), "R4 counts after unfreeze");

      // R6 clear wins over a pulse in the same cycle
      @(negedge clk);
      ev[8] = 1'b1; wr_en = 1'b1; wr_addr = 8'h08; wr_data = (64'd8 << 16) | 64'd1;
      @(negedge clk);
      ev = '0; wr_en = 1'b0;
      idle(1);
      rd(8'h10, v0); check(64'(v0[CW-1:0]), 64'd0, "R6 clear beats pulse");
      wr_ctrl(64'd0);
      idle(5);
      rd(8'h18, v0); check(64'(v0[CW-1:0]), 64'd0, "R6 other event cleared");

      // R9 wrap
      for (int k = 0; k < 300; k++) begin
         ev[0] = 1'b1;
         ev[NE] = (k < 3);
         @(negedge clk);
      end
      ev = '0;
      idle(2);
      rd(8'h10, v0); check(64'(v0[CW-1:0]), 64'(300 % 256), "R9 wrap slice0");
      rd(8'h18, v0); check(64'(v0[CW-1:0]), 64'd3, "R9 no wrap slice1");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule